// File: doc/BRIEF.md
# Dual-Address DMA Transfer Engine

This block is a single DMA channel that copies a programmed number of units from one memory area to another. Each unit is moved by a read on the master bus from the source address, followed by a write of the same data to the destination address. The data is held in an internal holding register between the two phases. The read and the write of one unit are locked together, so that no other bus activity can come between them.

Software programs four registers while the channel is idle: source address, destination address, unit count and control. Writing the control register with its start bit set launches the run. The control register also selects:
- the unit size;
- the width of the data bus;
- how each address moves after a unit;
- whether an idle cycle precedes every read;
- whether the transfer-end output is driven.

When a unit does not fit the bus in one cycle, the engine splits it into several consecutive sub-cycles. This happens when the bus is narrower than the unit or the address is misaligned. The transfer-end output marks every cycle of the final unit. The acknowledge output is never driven in this addressing scheme.

Top module: `dma_dual_xfer`

## Requirements
- R1: The address of every read comes from the source register and the address of every write comes from the destination register. Each unit's bytes appear at the destination unchanged.
- R2: Each unit is a read phase followed by a write phase. The read strobe and the write strobe are never high together.
- R3: Unit size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, and bus width uses the same codes. The sub-cycle size reported on the size output uses the same codes.
  - If the phase's base address is a multiple of the unit size, the sub-cycle size is the smaller of the unit size and the bus width.
  - Otherwise every sub-cycle is one byte.
  - The phase issues unit size divided by sub-cycle size cycles, and each cycle's address is the base address plus the bytes already moved.
- R4: The lock output is high during every read and write cycle. A read phase is always followed directly, in the next cycle, by the write phase of the same unit.
- R5: Sub-cycle data is carried right-justified on the data buses. Read sub-cycles fill the holding register little-endian, from the lowest byte upward, and write sub-cycles unload it in the same order.
- R6: With control bit 1 set, the transfer-end output is high in every cycle of the final unit's read and write phases. With control bit 1 clear, it stays low.
- R7: With control bit 12 set, one idle cycle with no strobe precedes each read phase. This idle cycle also carries transfer-end when it belongs to the final unit.
- R8: The acknowledge output is always low.
- R9: Register selects are 0 = source, 1 = destination, 2 = count and 3 = control.
  - After each unit the count drops by one.
  - After the final unit, control bit 0 (active) reads 0 and control bit 10 (done) reads 1.
  - A write to the control register clears the done bit.
- R10: Control bits [7:6] set the source update and bits [9:8] set the destination update: 0 = fixed, 1 = increment by the unit size, 2 = decrement by the unit size. The two addresses move independently.
- R11: A control write with bit 0 set while the count is zero starts nothing: no bus cycle occurs and the active bit stays 0.
- R12: Register writes are ignored while the channel is active.
- R13: A cycle whose ready input is sampled low keeps its address and strobes unchanged in the next cycle.
- R14: After reset all registers read 0 and the read, write, lock and transfer-end outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| bus_addr_o | output | AW | Bus cycle address |
| bus_size_o | output | 2 | Sub-cycle size code |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_lock_o | output | 1 | Bus lock over each read/write pair |
| bus_wdata_o | output | 32 | Write data, right-justified |
| bus_rdata_i | input | 32 | Read data, right-justified |
| bus_rdy_i | input | 1 | Cycle completes when sampled high |
| tend_o | output | 1 | Transfer-end marker |
| dack_o | output | 1 | Acknowledge, held inactive |

## Verification
The bench keeps the default 32-bit address and 16-bit count. It sweeps every combination of unit size and bus width with three source/destination misalignment pairs. This reaches every sub-cycle split, from single cycles to four byte cycles, on both the read and the write side. Runs of three units with zero to two wait states are used, and the idle-cycle option alternates across the sweep. Extra runs cover fixed and decrementing addresses, a disabled transfer-end, a zero count, and register writes issued mid-run.

// File: rtl/dma_dual_pkg.sv
package dma_dual_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_RD, ST_WR} st_e;
  typedef enum logic [1:0] {AM_FIX = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_RSV = 2'd3} am_e;

  typedef struct packed {
    logic       idle_en;
    am_e        dmode;
    am_e        smode;
    logic [1:0] bw;
    logic [1:0] sz;
    logic       tend_en;
  } ctrl_t;

  function automatic logic [1:0] clamp_code(logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  function automatic logic [2:0] bytes_of(logic [1:0] c);
    return 3'd1 << clamp_code(c);
  endfunction

  function automatic logic [31:0] lane_mask(logic [1:0] c);
    case (clamp_code(c))
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/dma_dual_unit.sv
// Sub-cycle size and count for one phase.
module dma_dual_unit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    sz_i,
  input  logic [1:0]    bw_i,
  output logic [1:0]    ucode_o,
  output logic [2:0]    nsub_o
);
  import dma_dual_pkg::*;

  logic [1:0] esz, ebw, mn;
  logic       aligned;

  assign esz = clamp_code(sz_i);
  assign ebw = clamp_code(bw_i);
  assign mn  = (esz < ebw) ? esz : ebw;

  always_comb begin
    case (esz)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = ~base_i[0];
      default: aligned = (base_i[1:0] == 2'b00);
    endcase
  end

  assign ucode_o = aligned ? mn : 2'd0;
  assign nsub_o  = 3'd1 << (esz - ucode_o);
endmodule

// File: rtl/dma_dual_regs.sv
module dma_dual_regs #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [1:0]            reg_sel_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic                  xfer_done_i,
  output logic [AW-1:0]         src_o,
  output logic [AW-1:0]         dst_o,
  output logic [CW-1:0]         cnt_o,
  output dma_dual_pkg::ctrl_t   ctrl_o,
  output logic                  active_o
);
  import dma_dual_pkg::*;

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  ctrl_t         ctrl_q;
  logic          act_q, done_q;
  logic [2:0]    stp;
  logic          unused_wbits;

  assign stp          = bytes_of(ctrl_q.sz);
  assign unused_wbits = ^{reg_wdata_i[31:13], reg_wdata_i[11:10]};

  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, am_e m, logic [2:0] s);
    case (m)
      AM_INC:  return a + AW'(s);
      AM_DEC:  return a - AW'(s);
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (act_q) begin
      if (xfer_done_i) begin
        src_q <= next_addr(src_q, ctrl_q.smode, stp);
        dst_q <= next_addr(dst_q, ctrl_q.dmode, stp);
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end else if (reg_we_i) begin
      case (reg_sel_i)
        2'd0: src_q <= reg_wdata_i[AW-1:0];
        2'd1: dst_q <= reg_wdata_i[AW-1:0];
        2'd2: cnt_q <= reg_wdata_i[CW-1:0];
        default: begin
          ctrl_q.tend_en <= reg_wdata_i[1];
          ctrl_q.sz      <= reg_wdata_i[3:2];
          ctrl_q.bw      <= reg_wdata_i[5:4];
          ctrl_q.smode   <= am_e'(reg_wdata_i[7:6]);
          ctrl_q.dmode   <= am_e'(reg_wdata_i[9:8]);
          ctrl_q.idle_en <= reg_wdata_i[12];
          act_q          <= reg_wdata_i[0] && (cnt_q != '0);
          done_q         <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    case (reg_sel_i)
      2'd0: reg_rdata_o = 32'(src_q);
      2'd1: reg_rdata_o = 32'(dst_q);
      2'd2: reg_rdata_o = 32'(cnt_q);
      default: reg_rdata_o = {19'd0, ctrl_q.idle_en, 1'b0, done_q, ctrl_q.dmode,
                              ctrl_q.smode, ctrl_q.bw, ctrl_q.sz, ctrl_q.tend_en, act_q};
    endcase
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;
  assign ctrl_o   = ctrl_q;
  assign active_o = act_q;
endmodule

// File: rtl/dma_dual_seq.sv
// Phase sequencer: optional gap, locked read phase, write phase.
module dma_dual_seq #(
  parameter int AW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  dma_dual_pkg::ctrl_t ctrl_i,
  input  logic                last_i,
  input  logic [AW-1:0]       src_i,
  input  logic [AW-1:0]       dst_i,
  input  logic [1:0]          src_u_i,
  input  logic [2:0]          src_n_i,
  input  logic [1:0]          dst_u_i,
  input  logic [2:0]          dst_n_i,
  input  logic                bus_rdy_i,
  input  logic [31:0]         bus_rdata_i,
  output logic [AW-1:0]       bus_addr_o,
  output logic [1:0]          bus_size_o,
  output logic                bus_rd_o,
  output logic                bus_wr_o,
  output logic                bus_lock_o,
  output logic [31:0]         bus_wdata_o,
  output logic                tend_o,
  output logic                xfer_done_o
);
  import dma_dual_pkg::*;

  st_e         st_q, first_st;
  logic [2:0]  idx_q;
  logic [31:0] hold_q;
  logic [1:0]  ucode;
  logic [2:0]  nsub;
  logic [4:0]  off;
  logic [7:0]  shamt;
  logic [31:0] mask;
  logic        sub_last, in_wr, in_rd;

  assign in_rd    = (st_q == ST_RD);
  assign in_wr    = (st_q == ST_WR);
  assign ucode    = in_wr ? dst_u_i : src_u_i;
  assign nsub     = in_wr ? dst_n_i : src_n_i;
  assign off      = 5'(idx_q) << ucode;
  assign shamt    = {off, 3'b000};
  assign mask     = lane_mask(ucode);
  assign sub_last = (idx_q == nsub - 3'd1);
  assign first_st = ctrl_i.idle_en ? ST_GAP : ST_RD;
  assign xfer_done_o = in_wr && bus_rdy_i && sub_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (active_i) st_q <= first_st;
        end
        ST_GAP: st_q <= ST_RD;
        ST_RD: if (bus_rdy_i) begin
          if (sub_last) begin
            idx_q <= '0;
            st_q  <= ST_WR;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        default: if (bus_rdy_i) begin
          if (sub_last) begin
            idx_q <= '0;
            st_q  <= last_i ? ST_IDLE : first_st;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (in_rd && bus_rdy_i) begin
      hold_q <= (hold_q & ~(mask << shamt)) | ((bus_rdata_i & mask) << shamt);
    end
  end

  assign bus_rd_o    = in_rd;
  assign bus_wr_o    = in_wr;
  assign bus_lock_o  = in_rd | in_wr;
  assign bus_addr_o  = (in_wr ? dst_i : src_i) + AW'(off);
  assign bus_size_o  = (in_rd | in_wr) ? ucode : 2'd0;
  assign bus_wdata_o = in_wr ? ((hold_q >> shamt) & mask) : '0;
  assign tend_o      = ctrl_i.tend_en && last_i && (st_q != ST_IDLE);
endmodule

// File: rtl/dma_dual_xfer.sv
module dma_dual_xfer #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          bus_lock_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic          tend_o,
  output logic          dack_o
);
  import dma_dual_pkg::*;

  logic [AW-1:0] src_w, dst_w;
  logic [CW-1:0] cnt_w;
  ctrl_t         ctrl_w;
  logic          active_w, xfer_done_w, last_w;
  logic [1:0]    src_u, dst_u;
  logic [2:0]    src_n, dst_n;

  assign last_w = (cnt_w == CW'(1));
  assign dack_o = 1'b0;

  dma_dual_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .xfer_done_i(xfer_done_w), .src_o(src_w), .dst_o(dst_w), .cnt_o(cnt_w),
    .ctrl_o(ctrl_w), .active_o(active_w)
  );

  dma_dual_unit #(.AW(AW)) u_src_unit (
    .base_i(src_w), .sz_i(ctrl_w.sz), .bw_i(ctrl_w.bw), .ucode_o(src_u), .nsub_o(src_n)
  );

  dma_dual_unit #(.AW(AW)) u_dst_unit (
    .base_i(dst_w), .sz_i(ctrl_w.sz), .bw_i(ctrl_w.bw), .ucode_o(dst_u), .nsub_o(dst_n)
  );

  dma_dual_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .active_i(active_w), .ctrl_i(ctrl_w), .last_i(last_w),
    .src_i(src_w), .dst_i(dst_w), .src_u_i(src_u), .src_n_i(src_n),
    .dst_u_i(dst_u), .dst_n_i(dst_n), .bus_rdy_i, .bus_rdata_i,
    .bus_addr_o, .bus_size_o, .bus_rd_o, .bus_wr_o, .bus_lock_o, .bus_wdata_o,
    .tend_o, .xfer_done_o(xfer_done_w)
  );
endmodule

// File: rtl/dma_dual_chk.sv
module dma_dual_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic          bus_lock_o,
  input logic          bus_rdy_i,
  input logic          tend_o,
  input logic          dack_o,
  input logic          tend_en_i,
  input logic [CW-1:0] cnt_i
);
  a_r2_rw_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  a_r4_lock_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> bus_lock_o);

  a_r4_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_rd_o) && !bus_rd_o) |-> bus_wr_o);

  a_r8_no_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_o);

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_o || bus_wr_o) && !bus_rdy_i) |=>
      ($stable(bus_addr_o) && $stable(bus_rd_o) && $stable(bus_wr_o)));

  a_r6_tend_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tend_en_i |-> !tend_o);

  a_r6_tend_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend_o |-> (cnt_i == CW'(1)));
endmodule

bind dma_dual_xfer dma_dual_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o),
  .bus_wr_o(bus_wr_o), .bus_lock_o(bus_lock_o), .bus_rdy_i(bus_rdy_i),
  .tend_o(tend_o), .dack_o(dack_o), .tend_en_i(ctrl_w.tend_en), .cnt_i(cnt_w)
);

// File: tb/dma_dual_xfer_tb_top.sv
`timescale 1ns/1ps
module dma_dual_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rd, bus_wr, bus_lock, tend, dack;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdy = 1'b0;

  always #5 clk = ~clk;

  dma_dual_xfer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_lock_o(bus_lock),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy),
    .tend_o(tend), .dack_o(dack)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bus model / monitors
  logic [7:0]  mem [256];
  bit          init_req = 0;
  int          wait_n = 0, wcnt = 0;
  int          rd_beats = 0, wr_beats = 0, tend_beats = 0, tend_gap = 0;
  int          dack_bad = 0, lock_bad = 0, hold_bad = 0;
  bit          p_wr, p_tend, prev_rd = 0, hold_chk = 0, h_rd, h_wr;
  logic [31:0] p_addr, p_data, h_addr;
  logic [1:0]  p_sz;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  always @(negedge clk) begin
    if (init_req) for (int i = 0; i < 256; i++) mem[i] = pat(i);
    if (bus_rdy) begin
      if (p_wr) begin
        for (int b = 0; b < (1 << p_sz); b++) mem[(p_addr + b) & 255] = p_data[8*b +: 8];
        wr_beats++;
      end else rd_beats++;
      if (p_tend) tend_beats++;
      bus_rdy = 1'b0;
      wcnt = 0;
    end
    if (tend && !(bus_rd || bus_wr)) tend_gap++;
    if (dack) dack_bad++;
    if ((bus_rd || bus_wr) && !bus_lock) lock_bad++;
    if (prev_rd && !bus_rd && !bus_wr) lock_bad++;
    if (hold_chk && (bus_addr != h_addr || bus_rd != h_rd || bus_wr != h_wr)) hold_bad++;
    prev_rd = bus_rd;
    hold_chk = 0;
    if (bus_rd || bus_wr) begin
      if (wcnt == wait_n) begin
        bus_rdy = 1'b1;
        p_wr = bus_wr; p_addr = bus_addr; p_sz = bus_size; p_data = bus_wdata; p_tend = tend;
        if (bus_rd) begin
          bus_rdata = '0;
          for (int b = 0; b < (1 << bus_size); b++) bus_rdata[8*b +: 8] = mem[(bus_addr + b) & 255];
        end
      end else begin
        wcnt++;
        hold_chk = 1; h_addr = bus_addr; h_rd = bus_rd; h_wr = bus_wr;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  function automatic int nsub(int sz, int bw, int a);
    int szb = 1 << sz, bwb = 1 << bw, u;
    u = ((a % szb) == 0) ? ((szb < bwb) ? szb : bwb) : 1;
    return szb / u;
  endfunction

  function automatic int stepv(int m, int szb);
    return (m == 1) ? szb : (m == 2) ? -szb : 0;
  endfunction

  task automatic run_case(int sz, int bw, int soff, int doff, int sm, int dm,
                          int cnt, int idle, int te, int wn, bit poke);
    logic [7:0]  exp_mem [256];
    logic [31:0] v;
    int szb = 1 << sz, src = 64 + soff, dst = 160 + doff;
    int b_rd, b_wr, b_tb, b_tg, b_dk, b_lk, b_hd, mism = 0, nr, nw;
    bit ok = 0;
    wait_n = wn;
    init_req = 1; @(negedge clk); #1 init_req = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    for (int k = 0; k < cnt; k++)
      for (int b = 0; b < szb; b++)
        exp_mem[(dst + k*stepv(dm, szb) + b) & 255] = pat((src + k*stepv(sm, szb) + b) & 255);
    nr = nsub(sz, bw, src); nw = nsub(sz, bw, dst);
    b_rd = rd_beats; b_wr = wr_beats; b_tb = tend_beats; b_tg = tend_gap;
    b_dk = dack_bad; b_lk = lock_bad; b_hd = hold_bad;
    reg_wr(0, src); reg_wr(1, dst); reg_wr(2, cnt);
    reg_wr(3, 1 | (te << 1) | (sz << 2) | (bw << 4) | (sm << 6) | (dm << 8) | (idle << 12));
    if (poke) begin reg_wr(0, 32'h55); reg_wr(2, 32'h9); end // R12
    for (int t = 0; t < 3000; t++) begin
      reg_rd(3, v);
      if (v[10]) begin ok = 1; break; end
    end
    check(ok, "R9 done raised", ok, 1);
    check(v[0] == 0, "R9 active cleared", v[0], 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    check(mism == 0, poke ? "R12 copy intact" : "R1 R5 data copied", mism, 0);
    check(rd_beats - b_rd == cnt*nr, "R3 read sub-cycles", rd_beats - b_rd, cnt*nr);
    check(wr_beats - b_wr == cnt*nw, "R3 write sub-cycles", wr_beats - b_wr, cnt*nw);
    check(tend_beats - b_tb == (te ? nr + nw : 0), "R6 tend cycles",
          tend_beats - b_tb, te ? nr + nw : 0);
    check(tend_gap - b_tg == ((te && idle) ? 1 : 0), "R7 tend idle cycle",
          tend_gap - b_tg, (te && idle) ? 1 : 0);
    check(dack_bad == b_dk, "R8 dack low", dack_bad - b_dk, 0);
    check(lock_bad == b_lk, "R4 lock pair", lock_bad - b_lk, 0);
    check(hold_bad == b_hd, "R13 hold on wait", hold_bad - b_hd, 0);
    check(!(bus_rd && bus_wr), "R2 strobes", bus_rd & bus_wr, 0);
    reg_rd(2, v); check(v == 0, "R9 count zero", v, 0);
    reg_rd(0, v); check(v == 32'(src + cnt*stepv(sm, szb)), "R10 source final", v, src + cnt*stepv(sm, szb));
    reg_rd(1, v); check(v == 32'(dst + cnt*stepv(dm, szb)), "R10 dest final", v, dst + cnt*stepv(dm, szb));
  endtask

  initial begin
    logic [31:0] v;
    int b_rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R14 reset state
    for (int s = 0; s < 4; s++) begin
      reg_rd(2'(s), v);
      check(v == 0, "R14 register reset", v, 0);
    end
    check(!bus_rd && !bus_wr && !bus_lock && !tend, "R14 bus idle", {bus_rd, bus_wr, bus_lock, tend}, 0);
    // sweep size x width x misalignment
    for (int sz = 0; sz < 3; sz++)
      for (int bw = 0; bw < 3; bw++)
        for (int al = 0; al < 3; al++)
          run_case(sz, bw, (al == 1) ? 1 : (al == 2) ? 2 : 0, (al == 1) ? 2 : (al == 2) ? 1 : 0,
                   1, 1, 3, bw & 1, 1, (sz + bw + al) % 3, 0);
    // R10 address modes
    run_case(2, 1, 0, 0, 2, 0, 3, 0, 1, 1, 0);
    run_case(1, 0, 0, 2, 0, 2, 4, 1, 1, 0, 0);
    run_case(0, 2, 3, 1, 2, 2, 2, 0, 1, 2, 0);
    // R6 tend disabled
    run_case(2, 2, 0, 0, 1, 1, 3, 1, 0, 1, 0);
    // R12 writes while active ignored
    run_case(2, 0, 0, 0, 1, 1, 3, 0, 1, 2, 1);
    // R11 zero count
    b_rd = rd_beats + wr_beats;
    reg_wr(2, 0);
    reg_wr(3, 32'h7);
    repeat (20) @(negedge clk);
    reg_rd(3, v);
    check(v[0] == 0, "R11 zero count not active", v[0], 0);
    check(rd_beats + wr_beats == b_rd, "R11 no bus cycles", rd_beats + wr_beats - b_rd, 0);
    check(v[10] == 0, "R9 control write clears done", v[10], 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule